// File: doc/BRIEF.md
# Reference Frequency Lock Detector

This block decides whether a recovered clock runs at the right frequency, using an optional reference. The recovered clock is presented as a count-enable `rec_en`, which pulses once per recovered-clock cycle. The reference is presented as `ref_en`, which pulses once per reference cycle. Both are sampled on a timebase clock `clk`, whose frequency stands for the middle of the oscillator band (2600 MHz by default, with the band spanning 2500 to 2700 MHz).

The block first measures the reference period in `clk` cycles. From that period it works out which of three ratios (16, 32 or 128) brings the scaled reference inside the band, and it keeps re-checking this on every reference edge. Once a ratio is known, it counts recovered ticks over a window of `2^WIN_LOG2 / ratio` reference periods, so a locked loop gives the same nominal count (8192 by default) at every ratio. Lock is declared after two consecutive windows fall within the ppm limit. A single failing window drops it again.

While unlocked, the block issues a one-cycle reacquire strobe at a fixed interval. A strap input marks the reference as absent. In that state no comparison is made and the block raises no alarm.

Top module: `lock_det`

## Requirements
- R1: After reset with `no_ref` low, `lol_n` is 0, `ratio_code` is 00 and `reacq` is 0.
- R2: A reference period of 16 `clk` cycles gives `ratio_code` 01, meaning divide-by-16. The code is valid from the second measured period onward.
- R3: Periods of 31 to 33 cycles give `ratio_code` 10, meaning divide-by-32. Periods of 30 and 34 give 00.
- R4: Periods of 124 to 133 cycles give `ratio_code` 11, meaning divide-by-128. A period of 123 gives 00.
- R5: A period that fits no band, or more than 133 cycles without a reference edge, gives `ratio_code` 00 and holds `lol_n` at 0.
- R6: A window is in tolerance when its recovered-tick count differs from 8192 by at most 5, which is the 650 ppm limit. With 5 dropped ticks per window the block stays locked; with 6 it loses lock.
- R7: `lol_n` rises only after two consecutive in-tolerance windows. One window alone does not raise it, and one failing window clears it.
- R8: While unlocked, `reacq` is a one-cycle pulse repeating every 4096 cycles. While locked it stays 0.
- R9: With `no_ref` high, `ratio_code` is 00, `lol_n` is 1 and `reacq` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase clock at the nominal band-centre rate |
| rst | input | 1 | Synchronous active-high reset |
| rec_en | input | 1 | One pulse per recovered-clock cycle |
| ref_en | input | 1 | One pulse per reference-clock cycle |
| no_ref | input | 1 | Strap: reference absent, comparison off |
| lol_n | output | 1 | Lock flag, low when out of lock |
| ratio_code | output | 2 | Detected ratio: 00 none, 01 /16, 10 /32, 11 /128 |
| reacq | output | 1 | One-cycle reacquire request while unlocked |

## Verification
The reference edge that closes one window also opens the next, and in that same cycle a recovered tick usually arrives. That tick must be counted in exactly one of the two windows. The bench keeps `rec_en` high on nearly every cycle, so every window boundary carries a tick. It drops a fixed number of ticks per 8192 cycles, and the outcome is judged at the tolerance edge: 5 drops must keep lock and 6 must lose it. A boundary tick that is lost or counted twice would shift one of these outcomes.

// File: rtl/lock_det_pkg.sv
package lock_det_pkg;

    typedef enum logic [1:0] {
        RC_NONE  = 2'b00,
        RC_DIV_A = 2'b01,
        RC_DIV_B = 2'b10,
        RC_DIV_C = 2'b11
    } ratio_code_e;

    // shortest reference period (timebase cycles) whose scaled frequency stays below the band top
    function automatic int per_min(input int div, input int fclk, input int band_hi);
        return (div * fclk + band_hi - 1) / band_hi;
    endfunction

    // longest reference period whose scaled frequency stays above the band bottom
    function automatic int per_max(input int div, input int fclk, input int band_lo);
        return (div * fclk) / band_lo;
    endfunction

endpackage

// File: rtl/ref_ratio_detect.sv
module ref_ratio_detect
    import lock_det_pkg::*;
#(
    parameter int DIV_A   = 16,
    parameter int DIV_B   = 32,
    parameter int DIV_C   = 128,
    parameter int FCLK    = 2600,
    parameter int BAND_LO = 2500,
    parameter int BAND_HI = 2700
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ref_en,
    input  logic        no_ref,
    output ratio_code_e code,
    output logic        code_chg
);
    localparam int DIVS [3] = '{DIV_A, DIV_B, DIV_C};
    localparam int PMAX_ALL = per_max(DIV_C, FCLK, BAND_LO);
    localparam int PW = $clog2(PMAX_ALL + 2);
    localparam logic [PW-1:0] PSAT = '1;

    typedef struct packed {
        logic [PW-1:0] per;
        logic          seen;
        ratio_code_e   code;
    } st_t;

    st_t st_d, st_q;
    logic [PW:0] period;
    logic [2:0]  hit;

    assign period = {1'b0, st_q.per} + 1'b1;

    for (genvar i = 0; i < 3; i++) begin : g_band
        localparam int LO = per_min(DIVS[i], FCLK, BAND_HI);
        localparam int HI = per_max(DIVS[i], FCLK, BAND_LO);
        assign hit[i] = (int'(period) >= LO) && (int'(period) <= HI);
    end

    always_comb begin
        st_d = st_q;
        if (no_ref) begin
            st_d.per  = '0;
            st_d.seen = 1'b0;
            st_d.code = RC_NONE;
        end else if (ref_en) begin
            st_d.per  = '0;
            st_d.seen = 1'b1;
            if (st_q.seen) begin
                if (hit[2])      st_d.code = RC_DIV_C;
                else if (hit[1]) st_d.code = RC_DIV_B;
                else if (hit[0]) st_d.code = RC_DIV_A;
                else             st_d.code = RC_NONE;
            end
        end else begin
            if (st_q.per != PSAT) st_d.per = st_q.per + 1'b1;
            if (int'(st_q.per) >= PMAX_ALL) st_d.code = RC_NONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{per: '0, seen: 1'b0, code: RC_NONE};
        end else begin
            st_q <= st_d;
        end
    end

    assign code     = st_q.code;
    assign code_chg = (st_d.code != st_q.code);

endmodule

// File: rtl/freq_window_cmp.sv
module freq_window_cmp
    import lock_det_pkg::*;
#(
    parameter int DIV_A    = 16,
    parameter int DIV_B    = 32,
    parameter int DIV_C    = 128,
    parameter int WIN_LOG2 = 13,
    parameter int TOL_PPM  = 650
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ref_en,
    input  logic        rec_en,
    input  logic        no_ref,
    input  ratio_code_e code,
    input  logic        code_chg,
    output logic        locked
);
    localparam int NOM = 1 << WIN_LOG2;
    localparam int TOL = (NOM * TOL_PPM) / 1000000;
    localparam int CW  = WIN_LOG2 + 2;
    localparam int RW  = $clog2(NOM / DIV_A + 1);
    localparam logic [CW-1:0] CSAT = '1;

    typedef struct packed {
        logic          active;
        logic [RW-1:0] refs;
        logic [CW-1:0] rcnt;
        logic          good;
        logic          lock;
    } st_t;

    st_t st_d, st_q;
    logic [RW-1:0] wlen;
    logic [CW-1:0] rec_inc;
    logic          in_tol;

    always_comb begin
        case (code)
            RC_DIV_A: wlen = RW'(NOM / DIV_A);
            RC_DIV_B: wlen = RW'(NOM / DIV_B);
            RC_DIV_C: wlen = RW'(NOM / DIV_C);
            default:  wlen = '1;
        endcase
    end

    assign rec_inc = (st_q.rcnt == CSAT) ? st_q.rcnt : st_q.rcnt + CW'(rec_en);
    assign in_tol  = (int'(st_q.rcnt) >= NOM - TOL) && (int'(st_q.rcnt) <= NOM + TOL);

    always_comb begin
        st_d = st_q;
        if (no_ref || code_chg || code == RC_NONE) begin
            st_d = '0;
        end else if (ref_en) begin
            if (st_q.active && st_q.refs == wlen - 1'b1) begin
                st_d.good = in_tol;
                st_d.lock = in_tol && st_q.good;
                st_d.refs = '0;
                st_d.rcnt = CW'(rec_en);
            end else if (st_q.active) begin
                st_d.refs = st_q.refs + 1'b1;
                st_d.rcnt = rec_inc;
            end else begin
                st_d.active = 1'b1;
                st_d.refs   = '0;
                st_d.rcnt   = CW'(rec_en);
            end
        end else if (st_q.active) begin
            st_d.rcnt = rec_inc;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign locked = st_q.lock;

endmodule

// File: rtl/reacq_timer.sv
module reacq_timer #(
    parameter int REACQ_CYC = 4096
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    output logic strobe
);
    localparam int TW = $clog2(REACQ_CYC);

    typedef struct packed {
        logic [TW-1:0] cnt;
        logic          stb;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.stb = 1'b0;
        if (!active) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == TW'(REACQ_CYC - 1)) begin
            st_d.cnt = '0;
            st_d.stb = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign strobe = st_q.stb;

endmodule

// File: rtl/lock_det.sv
module lock_det
    import lock_det_pkg::*;
#(
    parameter int DIV_A     = 16,
    parameter int DIV_B     = 32,
    parameter int DIV_C     = 128,
    parameter int FCLK      = 2600,
    parameter int BAND_LO   = 2500,
    parameter int BAND_HI   = 2700,
    parameter int WIN_LOG2  = 13,
    parameter int TOL_PPM   = 650,
    parameter int REACQ_CYC = 4096
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rec_en,
    input  logic       ref_en,
    input  logic       no_ref,
    output logic       lol_n,
    output logic [1:0] ratio_code,
    output logic       reacq
);
    ratio_code_e code;
    logic        code_chg;
    logic        locked;

    ref_ratio_detect #(
        .DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C),
        .FCLK(FCLK), .BAND_LO(BAND_LO), .BAND_HI(BAND_HI)
    ) u_detect (
        .clk(clk), .rst(rst), .ref_en(ref_en), .no_ref(no_ref),
        .code(code), .code_chg(code_chg)
    );

    freq_window_cmp #(
        .DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C),
        .WIN_LOG2(WIN_LOG2), .TOL_PPM(TOL_PPM)
    ) u_window (
        .clk(clk), .rst(rst), .ref_en(ref_en), .rec_en(rec_en), .no_ref(no_ref),
        .code(code), .code_chg(code_chg), .locked(locked)
    );

    reacq_timer #(
        .REACQ_CYC(REACQ_CYC)
    ) u_reacq (
        .clk(clk), .rst(rst), .active(!no_ref && !locked), .strobe(reacq)
    );

    assign lol_n      = locked || no_ref;
    assign ratio_code = code;

endmodule

// File: rtl/lock_det_chk.sv
module lock_det_chk (
    input logic       clk,
    input logic       rst,
    input logic       ref_en,
    input logic       no_ref,
    input logic       lol_n,
    input logic [1:0] ratio_code,
    input logic       reacq
);
    // R9
    strap_clears_code_chk: assert property (@(posedge clk) disable iff (rst)
        no_ref |=> ratio_code == 2'b00);

    // R8
    reacq_only_unlocked_chk: assert property (@(posedge clk) disable iff (rst)
        reacq |-> !$past(lol_n));

    // R8
    reacq_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        reacq |=> !reacq);

    // R7
    lock_rises_on_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (!no_ref && $past(!no_ref) && $rose(lol_n)) |-> $past(ref_en));

    // R5
    lock_needs_code_chk: assert property (@(posedge clk) disable iff (rst)
        (!no_ref && lol_n) |-> ratio_code != 2'b00);

endmodule

bind lock_det lock_det_chk u_chk (
    .clk(clk), .rst(rst), .ref_en(ref_en), .no_ref(no_ref),
    .lol_n(lol_n), .ratio_code(ratio_code), .reacq(reacq)
);

// File: tb/lock_det_tb.sv
`timescale 1ns/1ps
module lock_det_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rec_en = 1'b0;
    logic       ref_en = 1'b0;
    logic       no_ref = 1'b0;
    logic       lol_n;
    logic [1:0] ratio_code;
    logic       reacq;

    int  tests = 0;
    int  fails = 0;
    int  ref_per = 16;
    bit  ref_run = 1'b0;
    int  drops = 0;
    int  cyc = 0;
    int  ph = 0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    lock_det u_dut (
        .clk(clk), .rst(rst), .rec_en(rec_en), .ref_en(ref_en), .no_ref(no_ref),
        .lol_n(lol_n), .ratio_code(ratio_code), .reacq(reacq)
    );

    // stimulus generator: reference every ref_per cycles, recovered tick dropped on 'drops' residues per 8192
    initial begin
        forever begin
            @(negedge clk);
            cyc = cyc + 1;
            rec_en = !((cyc % 8192) < drops);
            if (ref_run) begin
                if (ph >= ref_per - 1) begin
                    ph = 0;
                    ref_en = 1'b1;
                end else begin
                    ph = ph + 1;
                    ref_en = 1'b0;
                end
            end else begin
                ref_en = 1'b0;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic count_strobes(input int n, output int cnt);
        cnt = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (reacq) cnt++;
        end
    endtask

    task automatic t_reset;
        wait_cyc(3);
        chk(lol_n == 1'b0, "R1 lol_n", lol_n, 0);
        chk(ratio_code == 2'b00, "R1 code", ratio_code, 0);
        chk(reacq == 1'b0, "R1 reacq", reacq, 0);
    endtask

    task automatic t_ratio(input int per, input int exp, input string req);
        ref_per = per;
        wait_cyc(4 * per + 4);
        chk(ratio_code == 2'(exp), req, ratio_code, exp);
    endtask

    task automatic t_lock;
        int n;
        ref_per = 16;
        drops = 0;
        wait_cyc(12000);
        chk(ratio_code == 2'b01, "R2 code stays /16", ratio_code, 1);
        chk(lol_n == 1'b0, "R7 one window not enough", lol_n, 0);
        wait_cyc(5500);
        chk(lol_n == 1'b1, "R7 lock after two windows", lol_n, 1);
        count_strobes(5000, n);
        chk(n == 0, "R8 no strobe when locked", n, 0);
    endtask

    task automatic t_tol;
        drops = 6;
        wait_cyc(17000);
        chk(lol_n == 1'b0, "R6 six drops unlock", lol_n, 0);
    endtask

    task automatic t_reacq;
        int gap;
        int guard;
        guard = 0;
        while (!reacq && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        chk(reacq == 1'b1, "R8 strobe seen", reacq, 1);
        @(negedge clk);
        chk(reacq == 1'b0, "R8 strobe width", reacq, 0);
        gap = 1;
        while (!reacq && gap < 6000) begin
            @(negedge clk);
            gap++;
        end
        chk(gap == 4096, "R8 strobe spacing", gap, 4096);
    endtask

    task automatic t_tol_back;
        drops = 5;
        wait_cyc(25000);
        chk(lol_n == 1'b1, "R6 five drops keep lock", lol_n, 1);
    endtask

    task automatic t_stop;
        ref_run = 1'b0;
        wait_cyc(150);
        chk(ratio_code == 2'b00, "R5 stopped ref code", ratio_code, 0);
        chk(lol_n == 1'b0, "R5 stopped ref lol_n", lol_n, 0);
    endtask

    task automatic t_strap;
        int n;
        ref_run = 1'b1;
        ref_per = 16;
        no_ref = 1'b1;
        wait_cyc(3);
        chk(ratio_code == 2'b00, "R9 strap code", ratio_code, 0);
        chk(lol_n == 1'b1, "R9 strap lol_n", lol_n, 1);
        count_strobes(5000, n);
        chk(n == 0, "R9 strap no strobe", n, 0);
    endtask

    initial begin
        wait_cyc(4);
        rst = 1'b0;
        t_reset();
        ref_run = 1'b1;
        t_ratio(16,  1, "R2 period 16");
        t_ratio(32,  2, "R3 period 32");
        t_ratio(31,  2, "R3 period 31");
        t_ratio(33,  2, "R3 period 33");
        t_ratio(30,  0, "R3 period 30");
        t_ratio(34,  0, "R3 period 34");
        t_ratio(128, 3, "R4 period 128");
        t_ratio(124, 3, "R4 period 124");
        t_ratio(133, 3, "R4 period 133");
        t_ratio(123, 0, "R4 period 123");
        t_ratio(20,  0, "R5 period 20");
        chk(lol_n == 1'b0, "R5 no band lol_n", lol_n, 0);
        t_lock();
        t_tol();
        t_reacq();
        t_tol_back();
        t_stop();
        t_strap();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule